// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire configuration link. An external controller drives a serial clock, an active-low select and one shared data line. Through them it writes and reads a small byte-wide register array that the rest of the chip consumes as configuration. The block runs on the chip's system clock. It samples the serial clock and select as levels and acts on their edges, so the serial clock must be several times slower than the system clock.

Every frame starts with a 16-bit instruction. The instruction carries a read/write flag, a two-bit length code and a 13-bit start address, and data bytes follow it. On a read the block takes over the data line after the instruction. It presents each bit after a falling serial clock edge so that the controller can sample it on the next rising edge. The register address steps after every byte. The select line may be raised between bytes to stall a counted frame. Register 0 bit 0 sets whether data bytes are shifted MSB first or LSB first.

Top module: `spi3w_port`

## Requirements
- R1: After reset, sdioOe is 0 and every register reads 0. This means data bytes are MSB first.
- R2: Bits are sampled on rising sclk edges while csN is low. The instruction is always sent MSB first as bit 15 = read(1)/write(0), bits 14:13 = length code, bits 12:0 = start address. On a write, each completed data byte is stored at the current address.
- R3: Length codes 00, 01 and 10 carry one, two and three data bytes. After the last byte the frame is over, and further bits with csN still low open a new instruction.
- R4: After each data byte the address steps down by one in MSB-first mode and up by one in LSB-first mode, modulo 2^13.
- R5: On a read, sdioOe rises at the first falling sclk edge after the 16th instruction bit, never earlier. sdioOut changes only after a falling sclk edge (or a falling csN), and in MSB-first mode it gives bit 7 of the addressed register first.
- R6: At the end of a counted read frame, sdioOe returns to 0 after the rising edge of the final bit, even though csN stays low.
- R7: Length code 11 streams bytes with no limit. The frame ends only when csN goes high, and sdioOe stays 1 until then.
- R8: In a counted frame, csN going high at a byte boundary pauses the frame, and it resumes when csN falls. During a read pause sdioOe is 0, and the pending bit is driven again when csN falls.
- R9: csN going high in the middle of a byte aborts the frame and discards the partial byte. The next edges start a fresh instruction.
- R10: Register 0 bit 0 set to 1 selects LSB-first order for data bytes, both written and read. The instruction stays MSB first.
- R11: While csN is high, sclk and sdioIn have no effect on the registers and sdioOe is 0.
- R12: Addresses at or above REG_COUNT (16 by default) ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| csN | input | 1 | Active-low select from the controller |
| sdioIn | input | 1 | Data line as seen at the pad |
| sdioOut | output | 1 | Read data to the pad driver |
| sdioOe | output | 1 | Enable for the pad driver |
| cfgRegs | output | REG_COUNT*8 | Register array, register i at bits i*8+7:i*8 |

## Verification
The block registers sclk and csN once, so every action happens at the first system clock edge after the serial line changes. A written byte therefore appears on cfgRegs one clock after its eighth rising sclk edge. sdioOe and sdioOut change one clock after a falling sclk edge or falling csN. The bench holds each sclk half-phase for four system clocks and changes inputs on the falling system clock edge. It samples read data and enables at the end of the low phase, just before it raises sclk, and it samples register contents and enables four clocks after the last edge of a byte or a select change, so every result has settled before it is checked.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 13;
  localparam int IDX_W   = $clog2(BYTE_W);

  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA} portState_t;

  typedef struct packed {
    logic             instrShift;
    logic             instrDone;
    logic             dataBit;
    logic             byteDone;
    logic             wrCommit;
    logic             drive;
    logic [IDX_W-1:0] bitIdx;
  } portStrobe_t;

  // position of the n-th transferred bit inside a data byte
  function automatic logic [IDX_W-1:0] bitPos(logic [IDX_W-1:0] idx, logic lsbFirst);
    return lsbFirst ? idx : IDX_W'(BYTE_W - 1) - idx;
  endfunction
endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic [2:0]  instrHdr,
  output portStrobe_t st,
  output logic        sdioOe
);
  portState_t       state;
  logic             sclkQ, csQ;
  logic [IDX_W-1:0] bitCnt;
  logic             instrHi, isRead, stream;
  logic [1:0]       remain;
  logic             rise, fall, csFall, lastBit;

  assign rise    = !csN && sclk && !sclkQ;
  assign fall    = !csN && !sclk && sclkQ;
  assign csFall  = !csN && csQ;
  assign lastBit = (bitCnt == IDX_W'(BYTE_W - 1));

  always_comb begin
    st            = '0;
    st.instrShift = rise && (state != ST_DATA);
    st.instrDone  = rise && (state != ST_DATA) && lastBit && instrHi;
    st.dataBit    = rise && (state == ST_DATA) && !isRead;
    st.byteDone   = rise && (state == ST_DATA) && lastBit;
    st.wrCommit   = st.byteDone && !isRead;
    st.drive      = (state == ST_DATA) && isRead && (fall || csFall);
    st.bitIdx     = bitCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclkQ   <= 1'b0;
      csQ     <= 1'b1;
      bitCnt  <= '0;
      instrHi <= 1'b0;
      isRead  <= 1'b0;
      stream  <= 1'b0;
      remain  <= '0;
      sdioOe  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      if (csN) begin
        sdioOe <= 1'b0;
        // mid-byte, or end of a streaming data phase: frame is over
        if (bitCnt != '0 || (state == ST_DATA && stream)) begin
          state   <= ST_IDLE;
          bitCnt  <= '0;
          instrHi <= 1'b0;
        end
      end else if (rise) begin
        bitCnt <= bitCnt + IDX_W'(1);
        if (state != ST_DATA) begin
          state <= ST_INSTR;
          if (lastBit) begin
            if (instrHi) begin
              state   <= ST_DATA;
              isRead  <= instrHdr[2];
              stream  <= &instrHdr[1:0];
              remain  <= instrHdr[1:0];
              instrHi <= 1'b0;
            end else begin
              instrHi <= 1'b1;
            end
          end
        end else if (lastBit) begin
          if (!stream && remain == 2'd0) begin
            state  <= ST_IDLE;
            sdioOe <= 1'b0;
          end else if (!stream) begin
            remain <= remain - 2'd1;
          end
        end
      end else if (st.drive) begin
        sdioOe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi3w_dpath.sv
module spi3w_dpath
  import spi3w_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sdioIn,
  input  portStrobe_t                 st,
  output logic [2:0]                  instrHdr,
  output logic                        sdioOut,
  output logic [REG_COUNT*BYTE_W-1:0] cfgRegs
);
  logic [INSTR_W-2:0] instrSh;
  logic [INSTR_W-1:0] fullInstr;
  logic [ADDR_W-1:0]  addr, addrNew, addrStep;
  logic [BYTE_W-1:0]  rxSh, rxFull, txByte, rdNew, rdStep;
  logic [BYTE_W-1:0]  regs [REG_COUNT];
  logic               lsbFirst;
  logic [IDX_W-1:0]   pos;

  assign fullInstr = {instrSh, sdioIn};
  assign instrHdr  = fullInstr[INSTR_W-1:INSTR_W-3];
  assign addrNew   = fullInstr[ADDR_W-1:0];
  assign lsbFirst  = regs[0][0];
  assign pos       = bitPos(st.bitIdx, lsbFirst);
  assign addrStep  = lsbFirst ? addr + ADDR_W'(1) : addr - ADDR_W'(1);

  always_comb begin
    rxFull      = rxSh;
    rxFull[pos] = sdioIn;
  end

  always_comb begin
    rdNew  = '0;
    rdStep = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (addrNew == ADDR_W'(i))  rdNew  = regs[i];
      if (addrStep == ADDR_W'(i)) rdStep = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrSh <= '0;
      addr    <= '0;
      rxSh    <= '0;
      txByte  <= '0;
      sdioOut <= 1'b0;
    end else begin
      if (st.instrShift) instrSh <= fullInstr[INSTR_W-2:0];
      if (st.dataBit)    rxSh    <= rxFull;
      if (st.instrDone) begin
        addr   <= addrNew;
        txByte <= rdNew;
      end else if (st.byteDone) begin
        addr   <= addrStep;
        txByte <= rdStep;
      end
      if (st.drive) sdioOut <= txByte[pos];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (st.wrCommit) begin
      for (int i = 0; i < REG_COUNT; i++)
        if (addr == ADDR_W'(i)) regs[i] <= rxFull;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_cfg
    assign cfgRegs[g*BYTE_W +: BYTE_W] = regs[g];
  end
endmodule

// File: rtl/spi3w_port.sv
module spi3w_port
  import spi3w_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclk,
  input  logic                        csN,
  input  logic                        sdioIn,
  output logic                        sdioOut,
  output logic                        sdioOe,
  output logic [REG_COUNT*BYTE_W-1:0] cfgRegs
);
  portStrobe_t st;
  logic [2:0]  instrHdr;

  spi3w_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclk     (sclk),
    .csN      (csN),
    .instrHdr (instrHdr),
    .st       (st),
    .sdioOe   (sdioOe)
  );

  spi3w_dpath #(.REG_COUNT(REG_COUNT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .sdioIn   (sdioIn),
    .st       (st),
    .instrHdr (instrHdr),
    .sdioOut  (sdioOut),
    .cfgRegs  (cfgRegs)
  );
endmodule

// File: rtl/spi3w_port_chk.sv
module spi3w_port_chk #(
  parameter int REG_COUNT = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclk,
  input logic                   csN,
  input logic                   sdioOut,
  input logic                   sdioOe,
  input logic [REG_COUNT*8-1:0] cfgRegs
);
  // R11: a select held high for two samples leaves the line undriven
  p_idle_no_drive_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !sdioOe);

  // R5: the driver is enabled only in reaction to a falling sclk or csN
  p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdioOe) |-> (!$past(sclk) && $past(sclk, 2)) || (!$past(csN) && $past(csN, 2)));

  // R5: read data moves only after a falling sclk or csN
  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdioOut) |-> (!$past(sclk) && $past(sclk, 2)) || (!$past(csN) && $past(csN, 2)));

  // R2: registers change only on a rising sclk seen with select low
  p_write_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgRegs) |-> ($past(sclk) && !$past(sclk, 2) && !$past(csN)));

  // R11: with select high for two samples nothing is stored
  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && $past(csN, 2)) |-> $stable(cfgRegs));
endmodule

bind spi3w_port spi3w_port_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclk    (sclk),
  .csN     (csN),
  .sdioOut (sdioOut),
  .sdioOe  (sdioOe),
  .cfgRegs (cfgRegs)
);

// File: tb/spi3w_port_test.sv
`timescale 1ns/1ps
module spi3w_port_test;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe;
  logic [NREG*8-1:0] cfgRegs;
  logic [NREG*8-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic oeAll;

  always #10 clk = ~clk;

  spi3w_port #(.REG_COUNT(NREG)) uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .cfgRegs(cfgRegs)
  );

  // address 20 and 8191 lie outside the array
  localparam logic [20:0] VEC [6] = '{
    {13'd1, 8'h3C}, {13'd2, 8'h81}, {13'd5, 8'h5A},
    {13'd15, 8'hE7}, {13'd20, 8'h99}, {13'd8191, 8'h11}
  };

  task automatic chk(string tag, logic [NREG*8-1:0] act, logic [NREG*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (4) @(negedge clk);
  endtask

  task automatic putBit(input logic b);
    sclk = 1'b0; sdioIn = b; halfWait();
    sclk = 1'b1; halfWait();
  endtask

  task automatic getBit(output logic b);
    sclk = 1'b0; halfWait();
    b = sdioOut;
    oeAll = oeAll & sdioOe;
    sclk = 1'b1; halfWait();
  endtask

  task automatic sendInstr(input logic rd, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    w = {rd, len, a};
    for (int i = 15; i >= 0; i--) putBit(w[i]);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic lsb);
    for (int i = 0; i < 8; i++) putBit(lsb ? d[i] : d[7-i]);
  endtask

  task automatic getByte(output logic [7:0] d, input logic lsb);
    logic b;
    d = '0;
    oeAll = 1'b1;
    for (int i = 0; i < 8; i++) begin
      getBit(b);
      if (lsb) d[i] = b; else d[7-i] = b;
    end
  endtask

  task automatic csOn();
    csN = 1'b0; halfWait();
  endtask

  task automatic csOff();
    csN = 1'b1; halfWait();
  endtask

  task automatic modelWr(input int a, input logic [7:0] d);
    if (a < NREG) model[a*8 +: 8] = d;
  endtask

  function automatic logic [7:0] modelRd(input int a);
    return (a < NREG) ? model[a*8 +: 8] : 8'h00;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    halfWait();

    // R1 reset state
    chk("R1 oe", sdioOe, 0);
    chk("R1 regs", cfgRegs, 0);

    // table: one-byte write then one-byte read back (R2 R5 R12)
    for (int v = 0; v < 6; v++) begin
      csOn(); sendInstr(1'b0, 2'b00, VEC[v][20:8]); sendByte(VEC[v][7:0], 1'b0); csOff();
      modelWr(int'(VEC[v][20:8]), VEC[v][7:0]);
      chk("R2 R12 write", cfgRegs, model);
      csOn(); sendInstr(1'b1, 2'b00, VEC[v][20:8]); getByte(rd, 1'b0);
      chk("R5 R12 read", rd, modelRd(int'(VEC[v][20:8])));
      chk("R5 oe", oeAll, 1);
      csOff();
    end

    // R3 R4: three-byte write steps down, then a new instruction with csN low
    csOn(); sendInstr(1'b0, 2'b10, 13'd5);
    sendByte(8'hA1, 1'b0); sendByte(8'hB2, 1'b0); sendByte(8'hC3, 1'b0);
    sendInstr(1'b0, 2'b00, 13'd7); sendByte(8'h7E, 1'b0); csOff();
    modelWr(5, 8'hA1); modelWr(4, 8'hB2); modelWr(3, 8'hC3); modelWr(7, 8'h7E);
    chk("R3 R4 burst write", cfgRegs, model);

    // R3 read burst, R6 enable drops after last bit with csN low
    csOn(); sendInstr(1'b1, 2'b10, 13'd5);
    for (int k = 0; k < 3; k++) begin
      getByte(rd, 1'b0);
      chk("R3 R4 burst read", rd, modelRd(5 - k));
    end
    chk("R6 oe after frame", sdioOe, 0);
    csOff();

    // R5: no drive during the instruction
    csOn(); sendInstr(1'b1, 2'b00, 13'd1);
    chk("R5 oe before data", sdioOe, 0);
    getByte(rd, 1'b0);
    chk("R5 first read", rd, 8'h3C);
    csOff();

    // R7 streaming read runs past three bytes
    csOn(); sendInstr(1'b1, 2'b11, 13'd3);
    for (int k = 0; k < 4; k++) begin
      getByte(rd, 1'b0);
      chk("R7 stream read", rd, modelRd(3 - k));
    end
    chk("R7 oe held", sdioOe, 1);
    csOff();
    chk("R7 oe released", sdioOe, 0);

    // R7 streaming write
    csOn(); sendInstr(1'b0, 2'b11, 13'd12);
    sendByte(8'h10, 1'b0); sendByte(8'h20, 1'b0); sendByte(8'h30, 1'b0); csOff();
    modelWr(12, 8'h10); modelWr(11, 8'h20); modelWr(10, 8'h30);
    chk("R7 stream write", cfgRegs, model);

    // R8 paused write with R11 clock activity during the pause
    csOn(); sendInstr(1'b0, 2'b01, 13'd14); sendByte(8'h4D, 1'b0); csOff();
    for (int k = 0; k < 8; k++) putBit(k[0]);
    chk("R11 oe idle", sdioOe, 0);
    csOn(); sendByte(8'h6B, 1'b0); csOff();
    modelWr(14, 8'h4D); modelWr(13, 8'h6B);
    chk("R8 paused write", cfgRegs, model);

    // R8 paused read
    csOn(); sendInstr(1'b1, 2'b01, 13'd14); getByte(rd, 1'b0);
    chk("R8 pause byte0", rd, 8'h4D);
    csOff();
    chk("R8 oe in pause", sdioOe, 0);
    csOn();
    chk("R8 oe resumed", sdioOe, 1);
    getByte(rd, 1'b0);
    chk("R8 pause byte1", rd, 8'h6B);
    csOff();

    // R9 abort mid-byte discards the partial byte
    csOn(); sendInstr(1'b0, 2'b00, 13'd1);
    for (int k = 0; k < 4; k++) putBit(1'b1);
    csOff();
    chk("R9 abort", cfgRegs, model);
    csOn(); sendInstr(1'b0, 2'b00, 13'd1); sendByte(8'h42, 1'b0); csOff();
    modelWr(1, 8'h42);
    chk("R9 fresh frame", cfgRegs, model);

    // R11 whole frame with select high
    sendInstr(1'b0, 2'b00, 13'd2); sendByte(8'hEE, 1'b0);
    chk("R11 ignored regs", cfgRegs, model);
    chk("R11 ignored oe", sdioOe, 0);

    // R4 downward wrap from address 0 to 8191 (ignored)
    csOn(); sendInstr(1'b0, 2'b01, 13'd0); sendByte(8'hA4, 1'b0); sendByte(8'h77, 1'b0); csOff();
    modelWr(0, 8'hA4);
    chk("R4 wrap", cfgRegs, model);

    // R10 LSB-first order, address steps up
    csOn(); sendInstr(1'b0, 2'b00, 13'd0); sendByte(8'h01, 1'b0); csOff();
    modelWr(0, 8'h01);
    csOn(); sendInstr(1'b0, 2'b01, 13'd9); sendByte(8'h9C, 1'b1); sendByte(8'h35, 1'b1); csOff();
    modelWr(9, 8'h9C); modelWr(10, 8'h35);
    chk("R10 R4 lsb write", cfgRegs, model);
    csOn(); sendInstr(1'b1, 2'b01, 13'd9);
    getByte(rd, 1'b1); chk("R10 lsb read0", rd, 8'h9C);
    getByte(rd, 1'b1); chk("R10 lsb read1", rd, 8'h35);
    csOff();
    csOn(); sendInstr(1'b0, 2'b00, 13'd0); sendByte(8'h00, 1'b1); csOff();
    modelWr(0, 8'h00);
    chk("R10 restore", cfgRegs, model);
    csOn(); sendInstr(1'b1, 2'b00, 13'd9); getByte(rd, 1'b0); csOff();
    chk("R10 msb again", rd, 8'h9C);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule